// File: doc/BRIEF.md
# Atomic Memory Unit with Link Reservations

This block is a small word-addressed memory shared by several requesting ports. Each cycle at most one port is granted, and the lowest-numbered requesting port wins. The granted operation reads the addressed word, decides what to write, updates memory and sets or clears reservations, all on one clock edge. No other port can act between the read and the write, so each operation is indivisible.

The operations are plain load and store, plus four primitives for building locks and counters: swap, test-and-set, fetch-and-increment, and a load-linked / store-conditional pair. Each port has one reservation register. A load-linked arms that port's register on an address. Any write to that address disarms it, whichever port makes the write. A later store-conditional writes only if its own reservation is still armed on the same address. A spin lock uses the value 0 for free and 1 for held. A swap or test-and-set that returns 0 has acquired the lock.

Top module: `atomic_mem_unit`

## Requirements
- R1: During and after reset every memory word reads as 0, no reservation is armed, and `rsp_valid` is all zeros until a grant occurs.
- R2: Each cycle, `req_grant` has the bit of the lowest-numbered port whose `req_valid` is high and no other bit. A port that is not granted keeps its request pending.
- R3: A port granted in cycle N sees `rsp_valid` high on its own bit in cycle N+1, with its result on its `rsp_data` slice. No other port's `rsp_valid` bit rises.
- R4: Operation codes are 0 load, 1 store, 5 load-linked, 6 store-conditional, 2 swap, 3 test-and-set, 4 fetch-and-increment, and 7, which behaves as a load. Load returns the word and leaves it unchanged. Store writes the request data and returns the previous word.
- R5: Swap writes the request data and returns the previous word. A swap of 1 onto a lock word that returns 0 means the lock was taken.
- R6: Test-and-set writes 1 only when the word is 0 and returns the previous word. On a non-zero word it changes nothing.
- R7: Fetch-and-increment returns the word and stores the word plus one, wrapping modulo 2^DW.
- R8: Load-linked returns the word and arms the issuing port's reservation on that address. Store-conditional to the armed address writes the request data and returns 1.
- R9: A store-conditional returns 0 and leaves memory unchanged in three cases: the port's reservation was never armed, it is armed on a different address, or a write to the linked address has occurred since the port's load-linked. A write here means a store, swap, fetch-and-increment, successful test-and-set or successful store-conditional, from any port including the issuing one.
- R10: A store-conditional disarms the issuing port's reservation whether it succeeds or fails, so a second one without a new load-linked returns 0.
- R11: A load, a failed test-and-set, or a write to a different address leaves an armed reservation in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Request pending, one bit per port |
| req_op | input | 3*NPORTS | Operation code per port |
| req_addr | input | AW*NPORTS | Word address per port |
| req_wdata | input | DW*NPORTS | Write operand per port |
| req_grant | output | NPORTS | Port served this cycle |
| rsp_valid | output | NPORTS | Result available this cycle, per port |
| rsp_data | output | DW*NPORTS | Result word per port (store-conditional: 1 or 0) |

## Verification
Address sweeps store a distinct value at every word through rotating ports and read each word back through a different port. This separates address decoding and per-port slicing faults from operation faults. Every atomic operation runs against zero, one and an all-ones word, which covers both outcomes of test-and-set and the increment wrap. Load-linked / store-conditional sequences interleave stores to the same address, stores to other addresses, failed test-and-sets, cross-port writes and repeated store-conditionals, which tells disarming by address apart from disarming by port. Simultaneous requests from every subset of ports show the grant order and that held requests are served later with their own results.

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int NPORTS = 3,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_valid,
  input  logic [3*NPORTS-1:0]  req_op,
  input  logic [AW*NPORTS-1:0] req_addr,
  input  logic [DW*NPORTS-1:0] req_wdata,
  output logic [NPORTS-1:0]    req_grant,
  output logic [NPORTS-1:0]    rsp_valid,
  output logic [DW*NPORTS-1:0] rsp_data
);
  localparam int IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int DEPTH = 1 << AW;

  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_SWAP  = 3'd2;
  localparam logic [2:0] OP_TAS   = 3'd3;
  localparam logic [2:0] OP_FINC  = 3'd4;
  localparam logic [2:0] OP_LL    = 3'd5;
  localparam logic [2:0] OP_SC    = 3'd6;

  logic [DW-1:0]     mem   [DEPTH];
  logic [NPORTS-1:0] res_v;
  logic [AW-1:0]     res_a [NPORTS];

  logic          sel_fire;
  logic [IW-1:0] sel_idx;
  logic [2:0]    sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata, old_val, wr_val, result;
  logic          wr_en, link_ok;

  always_comb begin
    req_grant = '0;
    sel_idx   = '0;
    sel_fire  = 1'b0;
    for (int p = 0; p < NPORTS; p++)
      if (req_valid[p] && !sel_fire) begin
        req_grant[p] = 1'b1;
        sel_idx      = IW'(p);
        sel_fire     = 1'b1;
      end
  end

  assign sel_op    = req_op[int'(sel_idx)*3 +: 3];
  assign sel_addr  = req_addr[int'(sel_idx)*AW +: AW];
  assign sel_wdata = req_wdata[int'(sel_idx)*DW +: DW];
  assign old_val   = mem[sel_addr];
  assign link_ok   = res_v[sel_idx] && (res_a[sel_idx] == sel_addr);

  always_comb begin
    wr_en  = 1'b0;
    wr_val = sel_wdata;
    result = old_val;
    case (sel_op)
      OP_STORE, OP_SWAP: wr_en = 1'b1;
      OP_TAS: begin
        wr_en  = (old_val == '0);
        wr_val = DW'(1);
      end
      OP_FINC: begin
        wr_en  = 1'b1;
        wr_val = old_val + DW'(1);
      end
      OP_SC: begin
        wr_en  = link_ok;
        result = link_ok ? DW'(1) : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int p = 0; p < NPORTS; p++) res_a[p] <= '0;
      res_v     <= '0;
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_grant;
      if (sel_fire) begin
        rsp_data[int'(sel_idx)*DW +: DW] <= result;
        if (wr_en) mem[sel_addr] <= wr_val;
        for (int p = 0; p < NPORTS; p++) begin
          if (wr_en && res_a[p] == sel_addr) res_v[p] <= 1'b0;
          if (IW'(p) == sel_idx && sel_op == OP_SC) res_v[p] <= 1'b0;
          if (IW'(p) == sel_idx && sel_op == OP_LL) begin
            res_v[p] <= 1'b1;
            res_a[p] <= sel_addr;
          end
        end
      end
    end
  end
endmodule

module atomic_mem_unit_chk #(
  parameter int NPORTS = 3,
  parameter int DW     = 8,
  parameter int IW     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPORTS-1:0]    req_valid,
  input logic [NPORTS-1:0]    req_grant,
  input logic [NPORTS-1:0]    rsp_valid,
  input logic [DW*NPORTS-1:0] rsp_data,
  input logic                 sel_fire,
  input logic [2:0]           sel_op,
  input logic [IW-1:0]        sel_idx
);
  logic [IW-1:0] idx_q;
  logic [DW-1:0] rsp_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idx_q <= '0;
    else        idx_q <= sel_idx;

  assign rsp_word = rsp_data[int'(idx_q)*DW +: DW];

  always @(negedge clk)
    if (!rst_n) p_quiet_in_reset_r1: assert (rsp_valid == '0);

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));
  p_port0_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_grant[0]);
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);
  p_rsp_follows_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> rsp_valid == $past(req_grant));
  p_sc_flag_binary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fire && sel_op == 3'd6) |=> rsp_word <= DW'(1));
endmodule

bind atomic_mem_unit atomic_mem_unit_chk #(.NPORTS(NPORTS), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sel_fire(sel_fire),
  .sel_op(sel_op), .sel_idx(sel_idx)
);

// File: tb/tb_atomic_mem_unit.sv
module tb_atomic_mem_unit;
  localparam int NP = 3, AW = 4, DW = 8, DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [3*NP-1:0]  req_op = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [DW*NP-1:0] req_wdata = '0;
  logic [NP-1:0]    req_grant, rsp_valid;
  logic [DW*NP-1:0] rsp_data;

  atomic_mem_unit #(.NPORTS(NP), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [DW-1:0] mm [DEPTH];
  logic          rv [NP];
  int            ra [NP];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(int p, int op, int a, int wd);
    logic [DW-1:0] old = mm[a], r = mm[a], nv = DW'(wd);
    bit wr = 0;
    case (op)
      1, 2: wr = 1;
      3: begin wr = (old == 0); nv = 1; end
      4: begin wr = 1; nv = old + 1; end
      5: begin rv[p] = 1; ra[p] = a; end
      6: begin wr = rv[p] && ra[p] == a; r = wr ? 1 : 0; rv[p] = 0; end
      default: ;
    endcase
    if (wr) begin
      mm[a] = nv;
      for (int q = 0; q < NP; q++) if (ra[q] == a) rv[q] = 0;
    end
    return r;
  endfunction

  task automatic issue(int p, int op, int a, int wd, string tag);
    logic [DW-1:0] exp = model(p, op, a, wd);
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_op[p*3 +: 3] = 3'(op);
    req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = DW'(wd);
    #1 chk("R2 grant", req_grant, 1 << p);
    @(negedge clk);
    chk("R3 rsp_valid", rsp_valid, 1 << p);
    chk(tag, rsp_data[p*DW +: DW], exp);
    req_valid[p] = 1'b0;
  endtask

  task automatic contend(logic [NP-1:0] mask, int base);
    logic [NP-1:0] pend = mask, g;
    logic [DW-1:0] exp [NP];
    @(negedge clk);
    for (int p = 0; p < NP; p++) if (mask[p]) begin
      req_valid[p] = 1'b1;
      req_op[p*3 +: 3] = (p == 1) ? 3'd4 : 3'd0;
      req_addr[p*AW +: AW] = AW'(base);
      req_wdata[p*DW +: DW] = '0;
    end
    while (pend != 0) begin
      g = pend & (~pend + 1'b1);
      #1 chk("R2 lowest wins", req_grant, g);
      for (int p = 0; p < NP; p++) if (g[p]) exp[p] = model(p, (p == 1) ? 4 : 0, base, 0);
      @(negedge clk);
      chk("R3 held port answered", rsp_valid, g);
      for (int p = 0; p < NP; p++) if (g[p]) begin
        chk("R4 contended result", rsp_data[p*DW +: DW], exp[p]);
        req_valid[p] = 1'b0;
      end
      pend &= ~g;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    for (int p = 0; p < NP; p++) begin rv[p] = 0; ra[p] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    for (int a = 0; a < DEPTH; a++) issue(a % NP, 0, a, 0, "R1 word zero");
    for (int p = 0; p < NP; p++) issue(p, 6, 2, 9, "R1 no reservation");
    issue(0, 0, 2, 0, "R1 mem untouched");

    for (int a = 0; a < DEPTH; a++) issue(a % NP, 1, a, a * 7 + 3, "R4 store old");
    for (int a = 0; a < DEPTH; a++) issue((a + 1) % NP, (a % 2) ? 7 : 0, a, 0, "R4 load");

    issue(0, 1, 4, 0, "R4 clear lock");
    issue(1, 2, 4, 1, "R5 swap acquires");
    issue(2, 2, 4, 1, "R5 swap sees held");
    issue(0, 2, 4, 8'hA5, "R5 swap value");
    issue(0, 0, 4, 0, "R5 swap wrote");

    for (int v = 0; v < 3; v++) begin
      issue(1, 1, 5, (v == 2) ? 255 : v, "R4 setup");
      issue(2, 3, 5, 0, "R6 tas old");
      issue(0, 0, 5, 0, "R6 tas result");
      issue(1, 1, 5, (v == 2) ? 255 : v, "R4 setup");
      issue(2, 4, 5, 0, "R7 finc old");
      issue(0, 0, 5, 0, "R7 finc wrap");
    end

    issue(0, 5, 6, 0, "R8 ll value");
    issue(0, 6, 6, 8'h55, "R8 sc success");
    issue(1, 0, 6, 0, "R8 sc wrote");
    issue(0, 6, 6, 8'h66, "R10 second sc fails");
    issue(1, 0, 6, 0, "R10 mem unchanged");

    issue(0, 5, 7, 0, "R8 ll");
    issue(1, 5, 7, 0, "R8 ll");
    issue(2, 1, 7, 8'h11, "R9 foreign store");
    issue(0, 6, 7, 8'h22, "R9 sc fails p0");
    issue(1, 6, 7, 8'h33, "R9 sc fails p1");
    issue(2, 0, 7, 0, "R9 mem unchanged");

    issue(1, 5, 8, 0, "R8 ll");
    issue(2, 1, 9, 8'h44, "R11 other addr store");
    issue(0, 0, 8, 0, "R11 load");
    issue(1, 6, 8, 8'h77, "R11 sc survives");

    issue(1, 1, 10, 3, "R4 setup");
    issue(0, 5, 10, 0, "R8 ll");
    issue(2, 3, 10, 0, "R11 failed tas");
    issue(0, 6, 10, 8'h12, "R11 sc after failed tas");

    issue(0, 5, 11, 0, "R8 ll");
    issue(0, 1, 11, 8'h21, "R9 own store");
    issue(0, 6, 11, 8'h31, "R9 sc fails own store");
    issue(2, 5, 12, 0, "R8 ll");
    issue(1, 4, 12, 0, "R9 finc clears");
    issue(2, 6, 12, 8'h01, "R9 sc after finc");
    issue(2, 5, 13, 0, "R8 ll");
    issue(2, 6, 14, 8'h02, "R9 sc wrong addr");
    issue(2, 6, 13, 8'h03, "R10 cleared by failed sc");
    issue(1, 0, 14, 0, "R9 wrong addr untouched");

    for (int m = 1; m < (1 << NP); m++) contend(NP'(m), 15);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule